// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Aggregator

This block keeps the interrupt state for a disk controller with two channels and drives one shared active-high interrupt line. Each channel has a level interrupt input. A change of level on that input loads the channel's pending flag. The flag is stored twice: once in a per-channel legacy status byte, and once in a combined mode byte. The combined byte also holds a block bit for each channel. While a channel's block bit is set, that channel's pending flag cannot raise the shared line.

Software reaches the block through an 8-bit configuration register port that has already been decoded to a byte address, a write strobe and a data byte. It also has a separate side port that writes only the block bits. Pending flags are write-1-to-clear from either of their two locations. Every update copies the changed copy into the other copy, so the two always agree.

The shared line is computed from the stored state and registered, so it changes one clock after the state it reflects.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, every readable byte returns 0x00 and `irq_o` is low.
- R2: Read layout. Address 0x50 bit 2 holds channel 0 pending. Address 0x57 bit 4 holds channel 1 pending. Address 0x71 bits 2 and 3 hold channel 0 and channel 1 pending, and bits 4 and 5 hold the channel 0 and channel 1 block bits. Every other bit, and every other address, reads 0.
- R3: When a channel input differs from its value at the previous clock edge, that channel's pending flag takes the new level in both copies at that edge. A level that is held steady does not change the flag.
- R4: A config write of 1 to bit 2 at 0x50 clears channel 0 pending in both copies. A config write of 1 to bit 4 at 0x57 clears channel 1 pending in both copies. A 0 in that bit position leaves the flag unchanged.
- R5: A config write to 0x71 clears channel 0 pending where data bit 2 is 1 and channel 1 pending where data bit 3 is 1, in both copies.
- R6: Config writes never set a pending flag and never change a block bit.
- R7: A side-port write loads the block bits from data bits 5:4 (bit 4 for channel 0, bit 5 for channel 1) and leaves both pending flags unchanged.
- R8: At each clock edge, `irq_o` is loaded with 1 when some channel has its pending flag set and its block bit clear, using the state held before that edge.
- R9: If a channel input changes level in the same cycle as a write that clears that channel's flag, the flag takes the new input level.
- R10: The legacy copy and the combined copy of each pending flag are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config byte write strobe |
| cfg_addr_i | input | 8 | Config byte address, used for both reads and writes |
| cfg_wdata_i | input | 8 | Config write data |
| cfg_rdata_o | output | 8 | Config read data for `cfg_addr_i` (combinational) |
| side_we_i | input | 1 | Side-port write strobe for the block bits |
| side_wdata_i | input | 8 | Side-port data; only bits 5:4 are used |
| chan_irq_i | input | 2 | Level interrupt input of each channel |
| irq_o | output | 1 | Shared interrupt line, registered, active high |

## Verification
The assertions that tie the pending flags to write data assume that no channel input changes level in the same cycle, because an input change overrides a clear. They also assume that a config write and a side write do not land in the same cycle. The random stimulus does break both assumptions sometimes. Those properties are therefore guarded on the absence of the competing event rather than on the stimulus avoiding it. The bench's reference model applies all three sources in the same priority order (config write, then side write, then input change), so the overlapping cases are still checked at the ports. Channel inputs toggle only occasionally, so write-1-to-clear cases get long stretches to act on a flag whose input is held high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] LEG0_ADDR = 8'h50;
  localparam logic [ADDR_W-1:0] LEG1_ADDR = 8'h57;
  localparam logic [ADDR_W-1:0] CMB_ADDR  = 8'h71;

  localparam int LEG0_BIT     = 2;
  localparam int LEG1_BIT     = 4;
  localparam int CMB_PEND_LSB = 2;
  localparam int CMB_BLK_LSB  = 4;

  function automatic logic [ADDR_W-1:0] leg_addr(input int ch);
    return (ch == 0) ? LEG0_ADDR : LEG1_ADDR;
  endfunction

  function automatic int leg_bit(input int ch);
    return (ch == 0) ? LEG0_BIT : LEG1_BIT;
  endfunction
endpackage

// File: rtl/irq_agg_edge.sv
module irq_agg_edge
  import irq_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] lvl_i,
  output logic [NUM_CH-1:0] chg_o
);
  logic [NUM_CH-1:0] lvl_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= 1'b0;
      else         lvl_q[g] <= lvl_i[g];
    end
    assign chg_o[g] = lvl_i[g] ^ lvl_q[g];
  end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              side_we_i,
  input  logic [DATA_W-1:0] side_wdata_i,
  input  logic [NUM_CH-1:0] chg_i,
  input  logic [NUM_CH-1:0] lvl_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] blk_o
);
  logic [NUM_CH-1:0] leg_q, leg_d;
  logic [NUM_CH-1:0] cmb_q, cmb_d;
  logic [NUM_CH-1:0] blk_q, blk_d;
  logic              unused_data;

  assign unused_data = ^{side_wdata_i[DATA_W-1:CMB_BLK_LSB+NUM_CH],
                         side_wdata_i[CMB_BLK_LSB-1:0]};

  // Sources apply in order: config write, side write, input change.
  always_comb begin
    leg_d = leg_q;
    cmb_d = cmb_q;
    blk_d = blk_q;
    if (cfg_we_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfg_addr_i == leg_addr(c)) begin
          if (cfg_wdata_i[leg_bit(c)]) leg_d[c] = 1'b0;
          cmb_d = leg_d;
        end
      end
      if (cfg_addr_i == CMB_ADDR) begin
        cmb_d = cmb_d & ~cfg_wdata_i[CMB_PEND_LSB +: NUM_CH];
        leg_d = cmb_d;
      end
    end
    if (side_we_i) begin
      blk_d = side_wdata_i[CMB_BLK_LSB +: NUM_CH];
      leg_d = cmb_d;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (chg_i[c]) begin
        cmb_d[c] = lvl_i[c];
        leg_d[c] = cmb_d[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q <= '0;
      cmb_q <= '0;
      blk_q <= '0;
    end else begin
      leg_q <= leg_d;
      cmb_q <= cmb_d;
      blk_q <= blk_d;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cfg_addr_i == leg_addr(c)) cfg_rdata_o[leg_bit(c)] = leg_q[c];
    end
    if (cfg_addr_i == CMB_ADDR) begin
      cfg_rdata_o[CMB_PEND_LSB +: NUM_CH] = cmb_q;
      cfg_rdata_o[CMB_BLK_LSB +: NUM_CH]  = blk_q;
    end
  end

  assign pend_o = cmb_q;
  assign blk_o  = blk_q;

  // R10
  mirror_coherent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q == cmb_q);

  // R6
  blk_cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!side_we_i) |=> $stable(blk_q));

  // R5
  cmb_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CMB_ADDR && cfg_wdata_i[CMB_PEND_LSB] && !chg_i[0])
      |=> (!cmb_q[0] && !leg_q[0]));

  // R4
  leg1_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == LEG1_ADDR && cfg_wdata_i[LEG1_BIT] && !chg_i[1])
      |=> (!cmb_q[1] && !leg_q[1]));

  // R7
  side_pend_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (side_we_i && !cfg_we_i && chg_i == '0) |=> $stable(cmb_q));

  // R3
  in_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i[0] |=> (cmb_q[0] == $past(lvl_i[0])));
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out
  import irq_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] blk_i,
  output logic              irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_i & ~blk_i);
  end

  assign irq_o = irq_q;

  // R8
  blocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~blk_i) == '0) |=> !irq_q);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  input  logic       side_we_i,
  input  logic [7:0] side_wdata_i,
  input  logic [1:0] chan_irq_i,
  output logic       irq_o
);
  logic [NUM_CH-1:0] chg;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] blk;

  irq_agg_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (chan_irq_i),
    .chg_o  (chg)
  );

  irq_agg_regs i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .side_we_i    (side_we_i),
    .side_wdata_i (side_wdata_i),
    .chg_i        (chg),
    .lvl_i        (chan_irq_i),
    .pend_o       (pend),
    .blk_o        (blk)
  );

  irq_agg_out i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .blk_i  (blk),
    .irq_o  (irq_o)
  );

  // R8
  irq_follows_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(pend & ~blk))));
endmodule

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       side_we = 1'b0;
  logic [7:0] side_wdata = 8'h00;
  logic [1:0] chan_irq = 2'b00;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] m_pend = 2'b00;
  logic [1:0] m_blk  = 2'b00;
  logic [1:0] m_prev = 2'b00;
  logic       m_irq  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg i_irq_status_agg (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_addr_i   (cfg_addr),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata),
    .side_we_i    (side_we),
    .side_wdata_i (side_wdata),
    .chan_irq_i   (chan_irq),
    .irq_o        (irq)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [7:0] v = 8'h00;
    if (a == 8'h50) v[2] = m_pend[0];
    if (a == 8'h57) v[4] = m_pend[1];
    if (a == 8'h71) begin
      v[3:2] = m_pend;
      v[5:4] = m_blk;
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    cfg_we = 1'b0;
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp_read(a));
  endtask

  // Model step mirrors the requirement order: config write, side write, input change.
  task automatic model_edge();
    m_irq = |(m_pend & ~m_blk);
    if (cfg_we) begin
      if (cfg_addr == 8'h50 && cfg_wdata[2]) m_pend[0] = 1'b0;
      if (cfg_addr == 8'h57 && cfg_wdata[4]) m_pend[1] = 1'b0;
      if (cfg_addr == 8'h71) m_pend = m_pend & ~cfg_wdata[3:2];
    end
    if (side_we) m_blk = side_wdata[5:4];
    for (int c = 0; c < 2; c++)
      if (chan_irq[c] != m_prev[c]) m_pend[c] = chan_irq[c];
    m_prev = chan_irq;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R8", {7'd0, irq}, {7'd0, m_irq});
    cfg_we = 1'b0;
    side_we = 1'b0;
  endtask

  task automatic cwr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cycle();
  endtask

  task automatic swr(input logic [7:0] d);
    side_we = 1'b1; side_wdata = d;
    cycle();
  endtask

  task automatic rd_all(input string req);
    rd(req, 8'h50);
    rd(req, 8'h57);
    rd(req, 8'h71);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD*3);
    @(negedge clk);
    // R1
    rd_all("R1");
    check("R1", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cycle();
    rd("R1", 8'h10);

    // R3: raise channel 0
    chan_irq[0] = 1'b1;
    cycle();
    rd_all("R3");
    check("R3", cfg_rdata, 8'h04);
    cycle();
    check("R8", {7'd0, irq}, 8'h01);

    // R7: block channel 0 via side port
    swr(8'hFF & 8'h10);
    rd("R7", 8'h71);
    check("R7", cfg_rdata, 8'h14);
    cycle();
    check("R8", {7'd0, irq}, 8'h00);
    swr(8'h00);

    // R4: zero in position leaves flag, one clears both copies; held level stays cleared
    cwr(8'h50, 8'hFB);
    rd_all("R4");
    check("R4", cfg_rdata, 8'h04);
    cwr(8'h50, 8'h04);
    rd_all("R4");
    check("R4", cfg_rdata, 8'h00);
    cycle(); cycle();
    rd("R3", 8'h50);
    check("R3", cfg_rdata, 8'h00);

    // R5: clear channel 1 through combined byte
    chan_irq[1] = 1'b1;
    cycle();
    rd("R3", 8'h57);
    check("R3", cfg_rdata, 8'h10);
    cwr(8'h71, 8'h08);
    rd_all("R5");
    rd("R5", 8'h57);
    check("R5", cfg_rdata, 8'h00);

    // R6: config writes cannot set anything
    cwr(8'h71, 8'hF3);
    cwr(8'h50, 8'hFB);
    cwr(8'h57, 8'hEF);
    rd_all("R6");
    rd("R6", 8'h71);
    check("R6", cfg_rdata, 8'h00);

    // R9: input change beats a same-cycle clear
    chan_irq[1] = 1'b0;
    cycle();
    chan_irq[1] = 1'b1;
    cwr(8'h57, 8'h10);
    rd_all("R9");
    rd("R9", 8'h71);
    check("R9", cfg_rdata, 8'h08);

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      int sel;
      if ($urandom_range(0, 7) == 0) chan_irq[$urandom_range(0, 1)] ^= 1'b1;
      sel = $urandom_range(0, 9);
      if (sel < 2) begin
        cfg_we = 1'b1; cfg_addr = 8'h50; cfg_wdata = 8'($urandom);
      end else if (sel < 4) begin
        cfg_we = 1'b1; cfg_addr = 8'h57; cfg_wdata = 8'($urandom);
      end else if (sel < 6) begin
        cfg_we = 1'b1; cfg_addr = 8'h71; cfg_wdata = 8'($urandom);
      end else if (sel == 6) begin
        cfg_we = 1'b1; cfg_addr = 8'($urandom); cfg_wdata = 8'($urandom);
      end
      if ($urandom_range(0, 5) == 0) begin
        side_we = 1'b1; side_wdata = 8'($urandom);
      end
      cycle();
      if (i % 4 == 0) begin
        rd_all("R10");
        rd("R2", 8'($urandom));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule